// File: doc/BRIEF.md
# Processor Clock Power-State Controller

This block follows a processor core through its clock power states and decides when each low-power state may be entered and when it is left. It watches a halt request, an active-low stop-clock request, an active-low sleep request, a snoop request, a bus-clock-present indication and a microsecond tick. From these it drives a 3-bit state code and a set of registered control flags: whether the core may snoop, whether the core clock runs, whether illegal input activity was seen, and a one-cycle pulse when the core is fully awake again.

Each way out of a low-power state has its own latency, counted in cycles of `clk`, which stands for the bus clock. The one exception is the way out of Deep Sleep, which waits a number of microsecond ticks while the clock generator relocks. Loss of the bus clock is shown by `bus_clk_ok` going low. A static `quick_mode` input chooses which state a stop-clock request from Normal leads to.

Top module: `pstate_ctrl`

## Requirements
- R1: State codes are Normal=0, Auto Halt=1, Stop Grant=2, Quick Start=3, Snoop Service=4, Sleep=5, Deep Sleep=6. While `rst` is high at a clock edge in any state other than Deep Sleep, the block goes to Normal. After that edge `core_clk_en`=1, `snoop_ok`=1, `input_err`=0 and `wake_done`=0.
- R2: In Normal, a low `stop_req_n` moves the block at the next edge to Stop Grant when `quick_mode`=0, or to Quick Start when `quick_mode`=1. A stop request outranks `halt_req`. Otherwise, a high `halt_req` moves the block to Auto Halt.
- R3: Exit latencies are counted from the edge that first samples the exit condition. The state changes on the Nth edge after that one. Auto Halt goes to Normal with N=10 once `halt_req` is low. Stop Grant goes to Normal with N=10 once `stop_req_n` is high. Quick Start goes to Normal with N=8 once `stop_req_n` is high. Sleep goes to Stop Grant with N=10 once `sleep_req_n` is high.
- R4: In Auto Halt, Stop Grant or Quick Start with no exit count running, a high `snoop_req` moves the block to Snoop Service at the next edge. Once `snoop_req` is low, the block returns to the state it came from on the 3rd edge after the edge that first samples it low.
- R5: In Stop Grant, a low `sleep_req_n` moves the block to Sleep at the next edge. This takes priority over a snoop and over the exit to Normal.
- R6: A low `bus_clk_ok` moves the block to Deep Sleep at the next edge only when it is in Sleep or Quick Start. In every other state a low `bus_clk_ok` has no effect.
- R7: In Deep Sleep, once `bus_clk_ok` is high, the block counts `us_tick` pulses sampled on later edges. It returns to the state it entered from (Sleep or Quick Start) on the edge that samples the 30th pulse.
- R8: `snoop_ok` is low exactly in Sleep and Deep Sleep. `core_clk_en` is high exactly in Normal.
- R9: `wake_done` is high for exactly one cycle: the first cycle in Normal after a move from another state. Reset does not raise it.
- R10: In Sleep or Deep Sleep, a change between two edges on `halt_req`, `stop_req_n`, `snoop_req` or `quick_mode` sets `input_err`. The flag stays set until a reset taken outside Deep Sleep.
- R11: A high `rst` in Deep Sleep does not change the state and sets `input_err`.
- R12: While an exit count runs, every other request (snoop, sleep, bus-clock loss) is ignored until the count completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock domain, rising edge |
| rst | input | 1 | Synchronous active-high reset request |
| halt_req | input | 1 | Core halt request |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| snoop_req | input | 1 | Bus snoop request |
| bus_clk_ok | input | 1 | High while the bus clock is running |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| quick_mode | input | 1 | Static: stop-clock goes to Quick Start when high |
| state_code | output | 3 | Current power state code |
| snoop_ok | output | 1 | Snooping is possible in this state |
| core_clk_en | output | 1 | Core clock enable |
| input_err | output | 1 | Sticky illegal-input-activity flag |
| wake_done | output | 1 | One-cycle pulse on return to Normal |

## Verification
The bound checker checks the following on every cycle. The snoop and core-clock flags must agree with the state code. The wake pulse may appear only on a real re-entry into Normal. Deep Sleep may be entered only from Sleep or Quick Start while the bus clock is missing, and left only back to one of those two. A watched input that changes during Sleep must raise the error flag. Only the directed scenarios show the following: the exact edge counts of each exit path, the 30-tick relock, the priority rules, reset being refused in Deep Sleep, and requests being ignored while a count runs.

// File: rtl/pstate_pkg.sv
package pstate_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_AHALT  = 3'd1,
    ST_STOPG  = 3'd2,
    ST_QUICK  = 3'd3,
    ST_SNOOP  = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_DEEP   = 3'd6
  } pstate_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pstate_timer.sv
module pstate_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          start,
  input  logic          step,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= load;
    end else if (busy_q && step) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && step && (cnt_q == CW'(1));
endmodule

// File: rtl/pstate_guard.sv
module pstate_guard
  import pstate_pkg::*;
#(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  pstate_e       state,
  input  logic [WW-1:0] watched,
  output logic          err
);
  logic [WW-1:0] prev_q;
  logic          quiet;

  assign quiet = (state == ST_SLEEP) || (state == ST_DEEP);

  always_ff @(posedge clk) begin
    prev_q <= watched;
    if (rst) begin
      if (state == ST_DEEP) err <= 1'b1;
      else                  err <= 1'b0;
    end else if (quiet && (watched != prev_q)) begin
      err <= 1'b1;
    end
  end
endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
#(
  parameter int AH_EXIT_CLKS  = 10,
  parameter int SG_EXIT_CLKS  = 10,
  parameter int QS_EXIT_CLKS  = 8,
  parameter int SL_EXIT_CLKS  = 10,
  parameter int SNP_EXIT_CLKS = 3,
  parameter int RELOCK_TICKS  = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req,
  input  logic       stop_req_n,
  input  logic       sleep_req_n,
  input  logic       snoop_req,
  input  logic       bus_clk_ok,
  input  logic       us_tick,
  input  logic       quick_mode,
  output logic [2:0] state_code,
  output logic       snoop_ok,
  output logic       core_clk_en,
  output logic       input_err,
  output logic       wake_done
);
  localparam int MAXLAT = max_of(max_of(max_of(AH_EXIT_CLKS, SG_EXIT_CLKS),
                                        max_of(QS_EXIT_CLKS, SL_EXIT_CLKS)),
                                 max_of(SNP_EXIT_CLKS, RELOCK_TICKS));
  localparam int CW = $clog2(MAXLAT + 1);
  localparam int WW = 4;

  pstate_e       state_q, nxt, ret_q, nxt_ret;
  logic          t_start, t_step, t_busy, t_done, t_clr, rst_clr;
  logic [CW-1:0] t_load;

  // reset is honoured everywhere except in Deep Sleep
  always_comb begin
    rst_clr = rst;
    if (state_q == ST_DEEP) rst_clr = 1'b0;
  end

  always_comb begin
    nxt     = state_q;
    nxt_ret = ret_q;
    t_start = 1'b0;
    t_step  = 1'b1;
    t_load  = '0;
    case (state_q)
      ST_NORMAL: begin
        if (!stop_req_n) nxt = quick_mode ? ST_QUICK : ST_STOPG;
        else if (halt_req) nxt = ST_AHALT;
      end
      ST_AHALT: begin
        if (t_busy) begin
          if (t_done) nxt = ST_NORMAL;
        end else if (snoop_req) begin
          nxt = ST_SNOOP; nxt_ret = ST_AHALT;
        end else if (!halt_req) begin
          t_start = 1'b1; t_load = CW'(AH_EXIT_CLKS);
        end
      end
      ST_STOPG: begin
        if (t_busy) begin
          if (t_done) nxt = ST_NORMAL;
        end else if (!sleep_req_n) begin
          nxt = ST_SLEEP;
        end else if (snoop_req) begin
          nxt = ST_SNOOP; nxt_ret = ST_STOPG;
        end else if (stop_req_n) begin
          t_start = 1'b1; t_load = CW'(SG_EXIT_CLKS);
        end
      end
      ST_QUICK: begin
        if (t_busy) begin
          if (t_done) nxt = ST_NORMAL;
        end else if (!bus_clk_ok) begin
          nxt = ST_DEEP; nxt_ret = ST_QUICK;
        end else if (snoop_req) begin
          nxt = ST_SNOOP; nxt_ret = ST_QUICK;
        end else if (stop_req_n) begin
          t_start = 1'b1; t_load = CW'(QS_EXIT_CLKS);
        end
      end
      ST_SNOOP: begin
        if (t_busy) begin
          if (t_done) nxt = ret_q;
        end else if (!snoop_req) begin
          t_start = 1'b1; t_load = CW'(SNP_EXIT_CLKS);
        end
      end
      ST_SLEEP: begin
        if (t_busy) begin
          if (t_done) nxt = ST_STOPG;
        end else if (!bus_clk_ok) begin
          nxt = ST_DEEP; nxt_ret = ST_SLEEP;
        end else if (sleep_req_n) begin
          t_start = 1'b1; t_load = CW'(SL_EXIT_CLKS);
        end
      end
      ST_DEEP: begin
        t_step = us_tick;
        if (t_busy) begin
          if (t_done) nxt = ret_q;
        end else if (bus_clk_ok) begin
          t_start = 1'b1; t_load = CW'(RELOCK_TICKS);
        end
        if (rst) begin
          nxt = ST_DEEP; t_start = 1'b0; t_step = 1'b0;
        end
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  assign t_clr = rst_clr || (nxt != state_q);

  pstate_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .clr   (t_clr),
    .start (t_start),
    .step  (t_step),
    .load  (t_load),
    .busy  (t_busy),
    .done  (t_done)
  );

  pstate_guard #(.WW(WW)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .state   (state_q),
    .watched ({halt_req, stop_req_n, snoop_req, quick_mode}),
    .err     (input_err)
  );

  always_ff @(posedge clk) begin
    if (rst_clr) begin
      state_q     <= ST_NORMAL;
      ret_q       <= ST_NORMAL;
      snoop_ok    <= 1'b1;
      core_clk_en <= 1'b1;
      wake_done   <= 1'b0;
    end else begin
      state_q     <= nxt;
      ret_q       <= nxt_ret;
      snoop_ok    <= !((nxt == ST_SLEEP) || (nxt == ST_DEEP));
      core_clk_en <= (nxt == ST_NORMAL);
      wake_done   <= (nxt == ST_NORMAL) && (state_q != ST_NORMAL);
    end
  end

  assign state_code = state_q;
endmodule

// File: rtl/pstate_ctrl_chk.sv
module pstate_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       halt_req,
  input logic       bus_clk_ok,
  input logic [2:0] state_code,
  input logic       snoop_ok,
  input logic       core_clk_en,
  input logic       input_err,
  input logic       wake_done
);
  assert_code_legal_R1: assert property (@(posedge clk) disable iff (rst)
    state_code != 3'd7);

  assert_snoop_gate_R8: assert property (@(posedge clk) disable iff (rst)
    snoop_ok == !((state_code == 3'd5) || (state_code == 3'd6)));

  assert_core_clk_R8: assert property (@(posedge clk) disable iff (rst)
    core_clk_en == (state_code == 3'd0));

  assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wake_done |-> (state_code == 3'd0) && ($past(state_code) != 3'd0));

  assert_deep_entry_R6: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 3'd6) && ($past(state_code) != 3'd6)) |->
      ((($past(state_code) == 3'd3) || ($past(state_code) == 3'd5)) && !$past(bus_clk_ok)));

  assert_deep_return_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(state_code) == 3'd6) && (state_code != 3'd6)) |->
      ((state_code == 3'd3) || (state_code == 3'd5)));

  assert_sleep_change_R10: assert property (@(posedge clk) disable iff (rst)
    ((state_code == 3'd5) && (halt_req != $past(halt_req))) |=> input_err);
endmodule

bind pstate_ctrl pstate_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt_req    (halt_req),
  .bus_clk_ok  (bus_clk_ok),
  .state_code  (state_code),
  .snoop_ok    (snoop_ok),
  .core_clk_en (core_clk_en),
  .input_err   (input_err),
  .wake_done   (wake_done)
);

// File: tb/sim_pstate_ctrl.sv
module sim_pstate_ctrl;
  logic clk = 1'b0;
  logic rst, halt_req, stop_req_n, sleep_req_n, snoop_req, bus_clk_ok, us_tick, quick_mode;
  logic [2:0] state_code;
  logic snoop_ok, core_clk_en, input_err, wake_done;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pstate_ctrl u0 (
    .clk(clk), .rst(rst), .halt_req(halt_req), .stop_req_n(stop_req_n),
    .sleep_req_n(sleep_req_n), .snoop_req(snoop_req), .bus_clk_ok(bus_clk_ok),
    .us_tick(us_tick), .quick_mode(quick_mode), .state_code(state_code),
    .snoop_ok(snoop_ok), .core_clk_en(core_clk_en), .input_err(input_err),
    .wake_done(wake_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; halt_req = 1'b0; stop_req_n = 1'b1; sleep_req_n = 1'b1;
    snoop_req = 1'b0; bus_clk_ok = 1'b1; us_tick = 1'b0; quick_mode = 1'b0;
    edges(3);
    rst = 1'b0;
    edges(1);
  endtask

  task automatic relock(input int origin, input string req);
    bus_clk_ok = 1'b1; us_tick = 1'b0;
    edges(1);
    for (int i = 0; i < 29; i++) begin
      us_tick = 1'b1; edges(1);
      us_tick = 1'b0; edges(1);
    end
    chk({req, " still relocking after 29 ticks"}, state_code, 6);
    us_tick = 1'b1; edges(1);
    us_tick = 1'b0;
    chk({req, " back to origin on tick 30"}, state_code, origin);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state after reset", state_code, 0);
    chk("R1 core clock after reset", core_clk_en, 1);
    chk("R1 snoop_ok after reset", snoop_ok, 1);
    chk("R1 input_err after reset", input_err, 0);
    chk("R9 no wake pulse from reset", wake_done, 0);
  endtask

  task automatic t_autohalt();
    halt_req = 1'b1; edges(1);
    chk("R2 halt enters Auto Halt", state_code, 1);
    chk("R8 core clock off in Auto Halt", core_clk_en, 0);
    halt_req = 1'b0; edges(10);
    chk("R3 Auto Halt held for 10 edges", state_code, 1);
    edges(1);
    chk("R3 Auto Halt exits on edge 11", state_code, 0);
    chk("R9 wake pulse on Normal re-entry", wake_done, 1);
    edges(1);
    chk("R9 wake pulse lasts one cycle", wake_done, 0);
  endtask

  task automatic t_stopgrant();
    quick_mode = 1'b0; stop_req_n = 1'b0; halt_req = 1'b1; edges(1);
    chk("R2 stop outranks halt, Stop Grant", state_code, 2);
    halt_req = 1'b0; stop_req_n = 1'b1; edges(10);
    chk("R3 Stop Grant held for 10 edges", state_code, 2);
    edges(1);
    chk("R3 Stop Grant exits to Normal", state_code, 0);
  endtask

  task automatic t_quick_snoop();
    quick_mode = 1'b1; stop_req_n = 1'b0; edges(1);
    chk("R2 quick_mode selects Quick Start", state_code, 3);
    snoop_req = 1'b1; edges(1);
    chk("R4 snoop enters Snoop Service at once", state_code, 4);
    chk("R8 snoop_ok high in Snoop Service", snoop_ok, 1);
    snoop_req = 1'b0; edges(3);
    chk("R4 Snoop Service held 3 edges", state_code, 4);
    edges(1);
    chk("R4 return to Quick Start", state_code, 3);
    stop_req_n = 1'b1; edges(8);
    chk("R3 Quick Start held for 8 edges", state_code, 3);
    edges(1);
    chk("R3 Quick Start exits to Normal", state_code, 0);
    quick_mode = 1'b0; edges(1);
  endtask

  task automatic t_deep_quick();
    quick_mode = 1'b1; stop_req_n = 1'b0; edges(1);
    bus_clk_ok = 1'b0; edges(1);
    chk("R6 clock loss in Quick Start enters Deep Sleep", state_code, 6);
    chk("R8 snoop_ok low in Deep Sleep", snoop_ok, 0);
    relock(3, "R7 from Quick Start");
    do_reset();
  endtask

  task automatic t_sleep();
    stop_req_n = 1'b0; edges(1);
    sleep_req_n = 1'b0; edges(1);
    chk("R5 sleep request enters Sleep", state_code, 5);
    chk("R8 snoop_ok low in Sleep", snoop_ok, 0);
    bus_clk_ok = 1'b0; edges(1);
    chk("R6 clock loss in Sleep enters Deep Sleep", state_code, 6);
    relock(5, "R7 from Sleep");
    sleep_req_n = 1'b1; edges(10);
    chk("R3 Sleep held for 10 edges", state_code, 5);
    edges(1);
    chk("R3 Sleep exits to Stop Grant", state_code, 2);
    chk("R10 no error without illegal change", input_err, 0);
    do_reset();
  endtask

  task automatic t_err();
    stop_req_n = 1'b0; edges(1);
    sleep_req_n = 1'b0; edges(1);
    chk("R10 no error on legal Sleep entry", input_err, 0);
    halt_req = 1'b1; edges(1);
    chk("R10 halt change in Sleep flags error", input_err, 1);
    halt_req = 1'b0; edges(2);
    chk("R10 error is sticky", input_err, 1);
    do_reset();
    chk("R10 reset clears error", input_err, 0);
    chk("R1 reset from Sleep gives Normal", state_code, 0);
  endtask

  task automatic t_deep_rst();
    stop_req_n = 1'b0; edges(1);
    sleep_req_n = 1'b0; edges(1);
    bus_clk_ok = 1'b0; edges(1);
    rst = 1'b1; edges(2);
    chk("R11 reset refused in Deep Sleep", state_code, 6);
    chk("R11 reset in Deep Sleep flags error", input_err, 1);
    rst = 1'b0;
    relock(5, "R11 relock after refused reset");
    do_reset();
  endtask

  task automatic t_bclk_ignore();
    bus_clk_ok = 1'b0; edges(3);
    chk("R6 clock loss ignored in Normal", state_code, 0);
    stop_req_n = 1'b0; edges(1);
    edges(2);
    chk("R6 clock loss ignored in Stop Grant", state_code, 2);
    bus_clk_ok = 1'b1; stop_req_n = 1'b1; edges(11);
    chk("R3 Stop Grant exit after clock returns", state_code, 0);
  endtask

  task automatic t_pending();
    stop_req_n = 1'b0; edges(1);
    stop_req_n = 1'b1; edges(1);
    snoop_req = 1'b1; sleep_req_n = 1'b0; edges(4);
    chk("R12 snoop and sleep ignored during count", state_code, 2);
    edges(5);
    chk("R12 count still running at edge 10", state_code, 2);
    edges(1);
    chk("R12 count completes to Normal", state_code, 0);
    snoop_req = 1'b0; sleep_req_n = 1'b1; edges(1);
  endtask

  initial begin
    t_reset();
    t_autohalt();
    t_stopgrant();
    t_quick_snoop();
    t_deep_quick();
    t_sleep();
    t_err();
    t_deep_rst();
    t_bclk_ignore();
    t_pending();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule